// File: doc/BRIEF.md
# Level-Indexed Quantized Twiddle Table

This block feeds the butterflies of a split-radix FFT with coarse twiddle factors. The block returns the twiddle for index n and the twiddle for index 3n together. Each twiddle is given as a pair of small signed integers. The real code approximates QL·cos and the imaginary code approximates −QL·sin of the twiddle angle. Each code is rounded to the nearest integer. With these codes, a butterfly can replace its multiplier with shifts and adds. QL is the quantization factor.

The value of a twiddle depends only on the transform length of the current level and the index. It never depends on the data. For that reason a single read-only table, built at elaboration for the largest length NMAX, serves every level. A level of length 2^k reads that table with a stride of NMAX/2^k.

A request gives the level as its base-two logarithm and gives the index. One cycle later the block returns both twiddles from a registered dual-port table, with a valid strobe and an error flag.

Top module: `twiddle_lut`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid` and `rsp_err` are low and all four codes are zero.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req` high. When `req` is low the codes keep their previous values.
- R3: For a legal request with level length N = 2^`lvl_log2` and index n, `w1_re` = round(QL·cos(2πn/N)) and `w1_im` = round(−QL·sin(2πn/N)). Halves round away from zero, and the codes are two's complement.
- R4: For the same request, `w3_re` and `w3_im` are quantized the same way but use the angle 2π·3n/N.
- R5: Index 0 at any legal level returns (QL, 0) for both twiddles.
- R6: In a valid response without error, the first twiddle lies in the fourth quadrant: `w1_re` ≥ 0 and `w1_im` ≤ 0.
- R7: In a valid response without error, the second twiddle is never strictly in the first quadrant: `w3_re` > 0 and `w3_im` > 0 never occur together.
- R8: Level 2^k with index n returns the same four codes as level 2^(k+1) with index 2n, because both read the same table entries.
- R9: A request with n ≥ N/4 at a legal level gives `rsp_err` high in its response cycle, with all four codes zero.
- R10: A request whose `lvl_log2` lies outside 2..log2(NMAX) gives `rsp_err` high with all four codes zero.
- R11: No code has a magnitude above QL. Each code is log2(QL)+2 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| lvl_log2 | input | 4 | Base-two logarithm of the current level length (legal 2..8) |
| idx | input | 6 | Twiddle index n within the level |
| rsp_valid | output | 1 | Response strobe, one cycle after `req` |
| rsp_err | output | 1 | Request was out of range (index or level) |
| w1_re | output | 4 | Real code of the twiddle for index n |
| w1_im | output | 4 | Imaginary code of the twiddle for index n |
| w3_re | output | 4 | Real code of the twiddle for index 3n |
| w3_im | output | 4 | Imaginary code of the twiddle for index 3n |

## Verification
The assertions take `lvl_log2` and `idx` into account only in cycles where `req` is high. The index-0 property applies only when the level code is legal. The quadrant properties apply only to responses that are valid and carry no error, because an error response returns zero codes.

The stimulus changes `req`, `lvl_log2` and `idx` only on the falling edge, so they are stable at every rising edge. The stimulus sweeps every legal index at every legal level. It also drives illegal indices and level codes, mixed with idle cycles, so that the held-code rule and the error path are both exercised.

// File: rtl/twq_pkg.sv
package twq_pkg;

  localparam real TWQ_PI = 3.14159265358979323846;

  // Round to nearest, halves away from zero.
  function automatic int twq_round(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

  typedef enum int {
    TWQ_PORT_W1 = 0,
    TWQ_PORT_W3 = 1
  } twq_port_e;

  localparam int TWQ_NPORT = 2;

endpackage

// File: rtl/twq_addr_gen.sv
module twq_addr_gen #(
  parameter int LOG_NMAX = 8,
  parameter int LVW      = 4,
  parameter int IW       = 6,
  parameter int AW       = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LVW-1:0] lvl,
  input  logic [IW-1:0]  idx,
  output logic           ok,
  output logic [AW-1:0]  a1,
  output logic [AW-1:0]  a3
);

  logic lvl_ok;

  always_comb begin
    lvl_ok = (lvl >= LVW'(2)) && (lvl <= LVW'(LOG_NMAX));
    ok     = 1'b0;
    a1     = '0;
    a3     = '0;
    if (lvl_ok) begin
      // the index must stay below N/4 = 2^(lvl-2)
      ok = ((idx >> (lvl - LVW'(2))) == '0);
      if (ok) begin
        // stride NMAX/N is a left shift by log2(NMAX) - lvl
        a1 = AW'(idx) << (LVW'(LOG_NMAX) - lvl);
        a3 = a1 + (a1 << 1);
      end
    end
  end

  AST_ADDR_SPAN: assert property (@(posedge clk) disable iff (rst)
    ok |-> (int'(a1) < (1 << (LOG_NMAX - 2))) && (int'(a3) < 3 * (1 << (LOG_NMAX - 2))));  // R4

  AST_ILLEGAL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ((lvl < LVW'(2)) || (lvl > LVW'(LOG_NMAX))) |-> !ok);  // R10

endmodule

// File: rtl/twq_rom.sv
module twq_rom
  import twq_pkg::*;
#(
  parameter int NMAX  = 256,
  parameter int QL    = 4,
  parameter int CW    = 4,
  parameter int DEPTH = 192,
  parameter int AW    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic [AW-1:0]        addr [TWQ_NPORT],
  output logic signed [CW-1:0] q_re [TWQ_NPORT],
  output logic signed [CW-1:0] q_im [TWQ_NPORT]
);

  logic [2*CW-1:0] mem [DEPTH];

  // Table contents computed once at elaboration
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      real ang;
      int  re_c;
      int  im_c;
      ang    = 2.0 * TWQ_PI * real'(k) / real'(NMAX);
      re_c   = twq_round(real'(QL) * $cos(ang));
      im_c   = twq_round(-real'(QL) * $sin(ang));
      mem[k] = {CW'(re_c), CW'(im_c)};
    end
  end

  for (genvar g = 0; g < TWQ_NPORT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        q_re[g] <= '0;
        q_im[g] <= '0;
      end else if (en) begin
        if (clr) begin
          q_re[g] <= '0;
          q_im[g] <= '0;
        end else begin
          q_re[g] <= mem[addr[g]][2*CW-1:CW];
          q_im[g] <= mem[addr[g]][CW-1:0];
        end
      end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      (en && !clr) |=> (int'(q_re[g]) <= QL) && (int'(q_re[g]) >= -QL) &&
                      (int'(q_im[g]) <= QL) && (int'(q_im[g]) >= -QL));  // R11
  end

endmodule

// File: rtl/twiddle_lut.sv
module twiddle_lut
  import twq_pkg::*;
#(
  parameter int NMAX = 256,
  parameter int QL   = 4,
  localparam int LOG_NMAX = $clog2(NMAX),
  localparam int LVW      = $clog2(LOG_NMAX + 1),
  localparam int IW       = LOG_NMAX - 2,
  localparam int CW       = $clog2(QL) + 2,
  localparam int DEPTH    = 3 * NMAX / 4,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [LVW-1:0]       lvl_log2,
  input  logic [IW-1:0]        idx,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic signed [CW-1:0] w1_re,
  output logic signed [CW-1:0] w1_im,
  output logic signed [CW-1:0] w3_re,
  output logic signed [CW-1:0] w3_im
);

  logic          ok;
  logic [AW-1:0] a1;
  logic [AW-1:0] a3;
  logic [AW-1:0] addr [TWQ_NPORT];
  logic signed [CW-1:0] q_re [TWQ_NPORT];
  logic signed [CW-1:0] q_im [TWQ_NPORT];

  twq_addr_gen #(
    .LOG_NMAX(LOG_NMAX),
    .LVW     (LVW),
    .IW      (IW),
    .AW      (AW)
  ) u_addr (
    .clk(clk),
    .rst(rst),
    .lvl(lvl_log2),
    .idx(idx),
    .ok (ok),
    .a1 (a1),
    .a3 (a3)
  );

  assign addr[TWQ_PORT_W1] = a1;
  assign addr[TWQ_PORT_W3] = a3;

  twq_rom #(
    .NMAX (NMAX),
    .QL   (QL),
    .CW   (CW),
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_rom (
    .clk (clk),
    .rst (rst),
    .en  (req),
    .clr (!ok),
    .addr(addr),
    .q_re(q_re),
    .q_im(q_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && !ok;
    end
  end

  assign w1_re = q_re[TWQ_PORT_W1];
  assign w1_im = q_im[TWQ_PORT_W1];
  assign w3_re = q_re[TWQ_PORT_W3];
  assign w3_im = q_im[TWQ_PORT_W3];

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rsp_valid && !rsp_err && (w1_re == '0) && (w3_im == '0));  // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);  // R2

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid && !rsp_err);  // R2

  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst)
    (req && idx == '0 && lvl_log2 >= LVW'(2) && lvl_log2 <= LVW'(LOG_NMAX)) |=>
      (int'(w1_re) == QL) && (w1_im == '0) && (int'(w3_re) == QL) && (w3_im == '0));  // R5

  AST_W1_FOURTH_QUAD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> (w1_re >= 0) && (w1_im <= 0));  // R6

  AST_W3_NOT_FIRST_QUAD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> !((w3_re > 0) && (w3_im > 0)));  // R7

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (w1_re == '0) && (w1_im == '0) && (w3_re == '0) && (w3_im == '0));  // R9

endmodule

// File: tb/sim_twiddle_lut.sv
module sim_twiddle_lut;

  localparam int NMAX = 256;
  localparam int QL   = 4;
  localparam int LOGN = 8;
  localparam real PI  = 3.14159265358979323846;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic [3:0]        lvl_log2 = '0;
  logic [5:0]        idx = '0;
  logic              rsp_valid;
  logic              rsp_err;
  logic signed [3:0] w1_re;
  logic signed [3:0] w1_im;
  logic signed [3:0] w3_re;
  logic signed [3:0] w3_im;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  twiddle_lut #(.NMAX(NMAX), .QL(QL)) u0 (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .lvl_log2 (lvl_log2),
    .idx      (idx),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .w1_re    (w1_re),
    .w1_im    (w1_im),
    .w3_re    (w3_re),
    .w3_im    (w3_im)
  );

  function automatic int rnd(input real x);
    if (x >= 0.0) return int'($floor(x + 0.5));
    return -int'($floor(-x + 0.5));
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int    e_v = 0, e_err = 0, e1r = 0, e1i = 0, e3r = 0, e3i = 0;
  string t1 = "R1", t3 = "R1", tv = "R1";

  always @(posedge clk) begin
    if (rst) begin
      e_v = 0; e_err = 0; e1r = 0; e1i = 0; e3r = 0; e3i = 0;
      t1 = "R1"; t3 = "R1"; tv = "R1";
    end else begin
      e_v   = int'(req);
      e_err = 0;
      tv    = "R2";
      if (req) begin
        int  l;
        int  n;
        real nl;
        l = int'(lvl_log2);
        n = int'(idx);
        if (l < 2 || l > LOGN) begin
          e_err = 1; e1r = 0; e1i = 0; e3r = 0; e3i = 0;
          t1 = "R10"; t3 = "R10"; tv = "R10";
        end else if (n >= (1 << (l - 2))) begin
          e_err = 1; e1r = 0; e1i = 0; e3r = 0; e3i = 0;
          t1 = "R9"; t3 = "R9"; tv = "R9";
        end else begin
          nl  = real'(1 << l);
          e1r = rnd(real'(QL) * $cos(2.0 * PI * real'(n) / nl));
          e1i = rnd(-real'(QL) * $sin(2.0 * PI * real'(n) / nl));
          e3r = rnd(real'(QL) * $cos(2.0 * PI * real'(3 * n) / nl));
          e3i = rnd(-real'(QL) * $sin(2.0 * PI * real'(3 * n) / nl));
          t1  = (n == 0) ? "R5" : "R3";
          t3  = (n == 0) ? "R5" : "R4";
        end
      end else begin
        t1 = "R2"; t3 = "R2";
      end
    end
  end

  always @(negedge clk) begin
    chk(tv, "rsp_valid", int'(rsp_valid), e_v);
    chk(tv, "rsp_err", int'(rsp_err), e_err);
    chk(t1, "w1_re", int'(w1_re), e1r);
    chk(t1, "w1_im", int'(w1_im), e1i);
    chk(t3, "w3_re", int'(w3_re), e3r);
    chk(t3, "w3_im", int'(w3_im), e3i);
    if (rsp_valid && !rsp_err) begin
      chk("R6", "w1 fourth quadrant", int'(w1_re >= 0 && w1_im <= 0), 1);
      chk("R7", "w3 outside first quadrant", int'(w3_re > 0 && w3_im > 0), 0);
      chk("R11", "w1_re magnitude ok", int'(w1_re <= QL && w1_re >= -QL), 1);
      chk("R11", "w3_im magnitude ok", int'(w3_im <= QL && w3_im >= -QL), 1);
    end
  end

  task automatic issue(input int l, input int n);
    @(negedge clk);
    req      = 1'b1;
    lvl_log2 = 4'(l);
    idx      = 6'(n);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  task automatic fetch(input int l, input int n, output int c[4]);
    issue(l, n);
    @(negedge clk);
    req  = 1'b0;
    c[0] = int'(w1_re); c[1] = int'(w1_im);
    c[2] = int'(w3_re); c[3] = int'(w3_im);
  endtask

  initial begin
    int a[4];
    int b[4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R3 R4 R5: every index at every level, back to back
    for (int l = 2; l <= LOGN; l++)
      for (int n = 0; n < (1 << (l - 2)); n++)
        issue(l, n);
    idle(3);  // R2: codes hold while idle

    // R9: first illegal index and the largest index per level
    for (int l = 2; l < LOGN; l++) begin
      issue(l, 1 << (l - 2));
      issue(l, 63);
      issue(l, 0);
      idle(1);
    end

    // R10: illegal level codes
    issue(0, 0);
    issue(1, 0);
    issue(9, 0);
    issue(15, 3);
    issue(8, 5);
    idle(2);

    // R8: level k, index n shares entries with level k+1, index 2n
    for (int l = 2; l < LOGN; l++) begin
      fetch(l, (1 << (l - 2)) - 1, a);
      fetch(l + 1, 2 * ((1 << (l - 2)) - 1), b);
      for (int i = 0; i < 4; i++) chk("R8", "shared entry", b[i], a[i]);
    end

    // R1: reset after activity clears outputs
    issue(6, 5);
    @(negedge clk);
    req = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    issue(7, 9);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule